// File: doc/BRIEF.md
# Software Store/Recall Unlock Detector

This block watches the control and address lines of an asynchronous-style SRAM port that has been brought into a synchronous clock domain. It looks for a fixed unlock pattern of six reads, each marked by chip enable going low. The last address of the pattern selects the command. One value requests a save of the SRAM into non-volatile storage, and a neighbouring value requests a restore. When the pattern completes, the block raises a single-cycle command toward the non-volatile engine. It then holds an I/O inhibit until that engine signals completion.

The first five reads are ordinary reads, and the array serves them as usual. The detector only observes them. Three things throw the pattern away: any write, any read at an unexpected address, and any store or recall that another source has already started. A save requested this way always goes ahead, whether or not the array was written since the last non-volatile operation. Output enable plays no part in whether a read counts.

Top module: `nvseq_detect`

## Requirements
- R1: After reset, `store_cmd`, `recall_cmd` and `io_inhibit` are all low, and no step of the pattern is pending.
- R2: Six reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, with no other access between them, give `store_cmd` high for exactly one clock. That clock follows the edge that sampled the sixth falling edge of `ce_n`. `recall_cmd` stays low.
- R3: The same five leading reads followed by a read at 0x0F0E give a one-clock `recall_cmd` pulse with the same timing. `store_cmd` stays low.
- R4: A clock edge that samples `ce_n` and `we_n` both low is a write. A write clears any partial progress, and finishing the remaining addresses afterwards gives no command.
- R5: A read whose address differs from the next expected one clears the progress. If that read was at 0x0000, it counts as the first step of a new attempt.
- R6: `oe_n` has no effect. A pattern read entirely with `oe_n` high gives its command just as it does with `oe_n` low.
- R7: `io_inhibit` goes high in the same clock as a command pulse. It stays high until the clock after an edge that samples `nv_done` high. While it is high, reads do not advance the pattern, and no command is issued. When `io_inhibit` is low, `nv_done` has no effect.
- R8: A clock edge that samples `nv_busy` high clears any partial progress.
- R9: `store_cmd` and `recall_cmd` are never high together, and neither is ever high for two clocks in a row.
- R10: A step is counted only at a high-to-low transition of `ce_n`. Holding `ce_n` low for several clocks counts as one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 13 | Address of the current access |
| ce_n | input | 1 | Chip enable, active low; its falling edge marks an access |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; observed but never qualifies a step |
| nv_busy | input | 1 | High while a store or recall started by another source runs |
| nv_done | input | 1 | One-clock pulse when the non-volatile operation finishes |
| store_cmd | output | 1 | One-clock request to save the array |
| recall_cmd | output | 1 | One-clock request to restore the array |
| io_inhibit | output | 1 | High while normal reads and writes must be blocked |

## Verification
Some properties are checked by assertions on every cycle. The two commands never overlap, and each lasts one clock. The inhibit never rises without a command and always drops after a completion pulse. No command appears while the inhibit is high. A write or an external busy always leaves the step counter at idle. Other behaviour depends on a whole stream of accesses, so only the bench scenarios can show it. These include: the exact address order, the choice between the two final addresses, the restart when a stray read hits 0x0000, counting a long chip-enable low only once, and independence from output enable. A scoreboard matches every command the block raises against the commands those scenarios predict.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int ADDR_W = 13;
  localparam int STEPS  = 6;
  localparam int STEP_W = $clog2(STEPS);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_STORE = 2'd1, CMD_RECALL = 2'd2} cmd_e;

  // Address expected at a given step of the unlock pattern (steps 0..STEPS-2).
  function automatic addr_t key_addr(input int idx);
    case (idx)
      0:       return addr_t'(13'h0000);
      1:       return addr_t'(13'h1555);
      2:       return addr_t'(13'h0AAA);
      3:       return addr_t'(13'h1FFF);
      default: return addr_t'(13'h10F0);
    endcase
  endfunction

  // Decode of the closing address into a command.
  function automatic cmd_e final_cmd(input addr_t a);
    if (a == addr_t'(13'h0F0F)) return CMD_STORE;
    if (a == addr_t'(13'h0F0E)) return CMD_RECALL;
    return CMD_NONE;
  endfunction

  // Next step after a qualified read that did not finish the pattern.
  function automatic step_t advance(input step_t cur, input addr_t a);
    if (int'(cur) < STEPS - 1 && a == key_addr(int'(cur))) return cur + step_t'(1);
    if (a == key_addr(0)) return step_t'(1);
    return step_t'(0);
  endfunction
endpackage

// File: rtl/nvseq_edge.sv
module nvseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic rd_strobe,
  output logic wr_seen
);
  logic ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_n;
  end

  assign rd_strobe = ce_q && !ce_n && we_n;
  assign wr_seen   = !ce_n && !we_n;

  AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe); // R10
endmodule

// File: rtl/nvseq_match.sv
module nvseq_match
  import nvseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_strobe,
  input  logic  wr_seen,
  input  logic  hold,
  input  logic  nv_busy,
  input  addr_t addr,
  output cmd_e  hit
);
  step_t step;
  logic  last_step;
  cmd_e  dec;

  assign last_step = (int'(step) == STEPS - 1);
  assign dec       = final_cmd(addr);
  assign hit       = (rd_strobe && !hold && last_step) ? dec : CMD_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   step <= '0;
    else if (hold || wr_seen)     step <= '0;
    else if (rd_strobe) begin
      if (last_step && dec != CMD_NONE) step <= '0;
      else                              step <= advance(step, addr);
    end
  end

  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen |=> (step == '0)); // R4
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> (step == '0)); // R8
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step) < STEPS); // R5
endmodule

// File: rtl/nvseq_cmd.sv
module nvseq_cmd
  import nvseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e hit,
  input  logic nv_done,
  output logic store_cmd,
  output logic recall_cmd,
  output logic io_inhibit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_cmd  <= 1'b0;
      recall_cmd <= 1'b0;
      io_inhibit <= 1'b0;
    end else begin
      store_cmd  <= 1'b0;
      recall_cmd <= 1'b0;
      if (io_inhibit) begin
        if (nv_done) io_inhibit <= 1'b0;
      end else if (hit != CMD_NONE) begin
        store_cmd  <= (hit == CMD_STORE);
        recall_cmd <= (hit == CMD_RECALL);
        io_inhibit <= 1'b1;
      end
    end
  end

  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_cmd && recall_cmd)); // R9
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    store_cmd |=> !store_cmd); // R9
  AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    recall_cmd |=> !recall_cmd); // R9
  AST_CMD_WITH_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cmd || recall_cmd) |-> io_inhibit); // R7
  AST_NO_HIT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    io_inhibit |-> (hit == CMD_NONE)); // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_inhibit && nv_done) |=> !io_inhibit); // R7
  AST_INHIBIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_inhibit) |-> (store_cmd || recall_cmd)); // R7
endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect
  import nvseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              nv_busy,
  input  logic              nv_done,
  output logic              store_cmd,
  output logic              recall_cmd,
  output logic              io_inhibit
);
  logic rd_strobe;
  logic wr_seen;
  logic hold;
  cmd_e hit;

  assign hold = nv_busy || io_inhibit;

  nvseq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .rd_strobe(rd_strobe), .wr_seen(wr_seen)
  );

  nvseq_match u_match (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .wr_seen(wr_seen),
    .hold(hold), .nv_busy(nv_busy), .addr(addr), .hit(hit)
  );

  nvseq_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .hit(hit), .nv_done(nv_done),
    .store_cmd(store_cmd), .recall_cmd(recall_cmd), .io_inhibit(io_inhibit)
  );

  AST_OE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(ce_n) && oe_n && we_n) |-> rd_strobe); // R6
endmodule

// File: tb/nvseq_detect_tb.sv
module nvseq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic        nv_busy = 1'b0, nv_done = 1'b0;
  logic        store_cmd, recall_cmd, io_inhibit;

  int n_vec = 0;
  int n_bad = 0;
  int exp_q[$];      // 1 = store, 2 = recall
  logic prev_cmd = 1'b0;

  always #10 clk = ~clk;

  nvseq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .nv_busy(nv_busy), .nv_done(nv_done),
    .store_cmd(store_cmd), .recall_cmd(recall_cmd), .io_inhibit(io_inhibit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard on every command the design raises.
  always @(negedge clk) begin
    if (rst_n) begin
      if (store_cmd || recall_cmd) begin
        check("R9 overlap/width", int'(store_cmd && recall_cmd) + int'(prev_cmd), 0);
        if (exp_q.size() == 0)
          check("R4/R5/R7/R8 unexpected command", {store_cmd, recall_cmd}, 0);
        else
          check("R2/R3 command kind", recall_cmd ? 2 : 1, exp_q.pop_front());
      end
      prev_cmd = store_cmd || recall_cmd;
    end
  end

  task automatic rd(input logic [12:0] a, input logic oe, input int low_cyc);
    addr = a; oe_n = oe; we_n = 1'b1; ce_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a);
    addr = a; we_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic lead5(input logic oe);
    rd(13'h0000, oe, 1); rd(13'h1555, oe, 1); rd(13'h0AAA, oe, 1);
    rd(13'h1FFF, oe, 1); rd(13'h10F0, oe, 1);
  endtask

  task automatic finish_run(input int code);
    if (code != 0) exp_q.push_back(code);
  endtask

  task automatic done_pulse(input string req);
    nv_done = 1'b1;
    @(negedge clk);
    nv_done = 1'b0;
    check(req, io_inhibit, 0);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 store_cmd at reset", store_cmd, 0);
    check("R1 recall_cmd at reset", recall_cmd, 0);
    check("R1 io_inhibit at reset", io_inhibit, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing pending, a lone closing read gives nothing
    rd(13'h0F0F, 1'b0, 1);
    check("R1 no pending step", io_inhibit, 0);

    // R2: store
    lead5(1'b0); finish_run(1); rd(13'h0F0F, 1'b0, 1);
    check("R2 inhibit after store", io_inhibit, 1);
    // R7: reads while inhibited do not count
    lead5(1'b0); rd(13'h0F0E, 1'b0, 1);
    check("R7 inhibit held", io_inhibit, 1);
    done_pulse("R7 release after done");

    // R7: done while idle has no effect, then R3 recall
    nv_done = 1'b1; @(negedge clk); nv_done = 1'b0;
    check("R7 idle done ignored", io_inhibit, 0);
    lead5(1'b0); finish_run(2); rd(13'h0F0E, 1'b0, 1);
    check("R3 inhibit after recall", io_inhibit, 1);
    done_pulse("R3 release");

    // R4: write in the middle aborts
    rd(13'h0000, 1'b0, 1); rd(13'h1555, 1'b0, 1); wr(13'h1FFF);
    rd(13'h0AAA, 1'b0, 1); rd(13'h1FFF, 1'b0, 1); rd(13'h10F0, 1'b0, 1); rd(13'h0F0F, 1'b0, 1);
    check("R4 no command after write", io_inhibit, 0);

    // R5: wrong address aborts
    rd(13'h0000, 1'b0, 1); rd(13'h1555, 1'b0, 1); rd(13'h0123, 1'b0, 1);
    rd(13'h0AAA, 1'b0, 1); rd(13'h1FFF, 1'b0, 1); rd(13'h10F0, 1'b0, 1); rd(13'h0F0F, 1'b0, 1);
    check("R5 no command after stray read", io_inhibit, 0);

    // R5: stray read of 0x0000 restarts at step two
    rd(13'h0000, 1'b0, 1); rd(13'h1555, 1'b0, 1); rd(13'h0000, 1'b0, 1);
    rd(13'h1555, 1'b0, 1); rd(13'h0AAA, 1'b0, 1); rd(13'h1FFF, 1'b0, 1); rd(13'h10F0, 1'b0, 1);
    finish_run(1); rd(13'h0F0F, 1'b0, 1);
    check("R5 restart store", io_inhibit, 1);
    done_pulse("R5 release");

    // R8: external busy clears progress
    rd(13'h0000, 1'b0, 1); rd(13'h1555, 1'b0, 1); rd(13'h0AAA, 1'b0, 1);
    nv_busy = 1'b1; @(negedge clk); nv_busy = 1'b0; @(negedge clk);
    rd(13'h1FFF, 1'b0, 1); rd(13'h10F0, 1'b0, 1); rd(13'h0F0F, 1'b0, 1);
    check("R8 no command after busy", io_inhibit, 0);

    // R6: outputs disabled, recall still recognised
    lead5(1'b1); finish_run(2); rd(13'h0F0E, 1'b1, 1);
    check("R6 recall with oe_n high", io_inhibit, 1);
    done_pulse("R6 release");

    // R10: long chip-enable low counts once
    rd(13'h0000, 1'b0, 1); rd(13'h1555, 1'b0, 5); rd(13'h0AAA, 1'b0, 1);
    rd(13'h1FFF, 1'b0, 3); rd(13'h10F0, 1'b0, 1);
    finish_run(1); rd(13'h0F0F, 1'b0, 4);
    check("R10 store with long enable", io_inhibit, 1);
    done_pulse("R10 release");

    repeat (3) @(negedge clk);
    check("R2/R3 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule